// File: doc/BRIEF.md
# Debug-Port Command Mailbox

This block is a small register file through which a host on a debug port gives commands to an on-chip executor by writing memory locations. A command is staged in fixed byte fields: an opcode, a 16-bit transfer size, a 32-bit target address, a result byte and a 32-bit error word. Next to these fields sits a separate byte buffer that carries the payload. The host writes the size, the address and any payload first. It writes the opcode last, and that write hands the command to the executor.

The executor sees a level `cmdValid` together with the staged fields. While the command is open it reads and writes the payload buffer through its own port. It ends the command with a one-cycle `exDone` that carries a result code and an error word. The mailbox stores the result before it returns the opcode to zero. A host that polls the opcode therefore finds a valid result once the opcode reads zero. After reset the result field holds a readiness code, which tells the host that the target is ready to accept commands.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the opcode, size and address fields read zero, the result field holds `READY_CODE` (default 0x5A), the error word reads zero, no command is pending and `cmdValid` is low.
- R2: The host address MSB selects the region: 0 selects the registers, decoded on the low four bits; 1 selects the payload buffer, indexed by the remaining bits. Register offsets are: 0x0 opcode, 0x2–0x3 size (little-endian), 0x4–0x7 address (little-endian), 0x8 result, 0x9–0xC error word (little-endian), 0xD pending flag in bit 0. Every other offset reads 0x00. Read data is valid in the cycle after the request.
- R3: While no command is pending, a host write of a nonzero byte to offset 0x0 stores it as the opcode. From the next cycle `cmdValid` is high and `cmdOpcode`, `cmdSize` and `cmdAddr` show the stored fields.
- R4: A host write of 0x00 to offset 0x0 does not start a command.
- R5: An `exDone` while `cmdValid` is high loads `exResult` into the result field at that edge and drops `cmdValid`. The opcode still holds its value for one more cycle. It clears to 0x00 at the following edge, and the pending flag falls at that same edge.
- R6: The error word takes `exError` only when `exResult` equals `ERR_CODE` (default 0x84). Any other result clears the error word to zero.
- R7: From the start of a command until the opcode clears, host writes to every register and to every payload byte are ignored.
- R8: The host cannot write the result field or the error word.
- R9: The payload buffer is a single-port byte RAM. While a command is pending and `exBufEn` is high, the executor owns the port and a host payload read in that cycle returns 0x00. Otherwise the host may read the buffer at any time and may write it only when no command is pending.
- R10: Executor buffer accesses while no command is pending are ignored.
- R11: `exDone` while `cmdValid` is low changes neither the result field nor the error word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostEn | input | 1 | Host access request |
| hostWe | input | 1 | Host write (1) or read (0) |
| hostAddr | input | PAY_AW+1 | Host byte address; MSB selects the payload region |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte, one cycle after the request |
| cmdValid | output | 1 | Command open toward the executor |
| cmdOpcode | output | 8 | Stored opcode |
| cmdSize | output | 16 | Stored size field |
| cmdAddr | output | 32 | Stored address field |
| exDone | input | 1 | Executor completion pulse |
| exResult | input | 8 | Result code presented with `exDone` |
| exError | input | 32 | Error word presented with `exDone` |
| exBufEn | input | 1 | Executor buffer access request |
| exBufWe | input | 1 | Executor buffer write (1) or read (0) |
| exBufAddr | input | PAY_AW | Executor buffer byte index |
| exBufWdata | input | 8 | Executor buffer write byte |
| exBufRdata | output | 8 | Executor buffer read byte, one cycle after the request |

## Verification
The bench builds the block with `PAY_AW` = 6, a 64-byte payload buffer. The host address is then 7 bits wide, so both the first and the last payload byte (0x40 and 0x7F) can be reached next to the register region. The default `READY_CODE` and `ERR_CODE` are kept. The readiness code can then be told apart from every completion code, and the conditional loading of the error word can be driven both ways. The small buffer lets a single run cover collisions between host and executor accesses at chosen indices.

// File: rtl/mb_pkg.sv
package mb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_CLOSE = 2'd2
  } mbState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic fieldWr;  // host write to a staging field
    logic opLoad;   // nonzero opcode accepted
    logic resLoad;  // capture executor completion
    logic opClear;  // return opcode to zero
    logic bufHost;  // host owns buffer port
    logic bufEx;    // executor owns buffer port
  } mbStrobe_t;

  localparam logic [3:0] OFF_OPC   = 4'h0;
  localparam logic [3:0] OFF_SIZE0 = 4'h2;
  localparam logic [3:0] OFF_SIZE1 = 4'h3;
  localparam logic [3:0] OFF_ADDR0 = 4'h4;
  localparam logic [3:0] OFF_ADDR1 = 4'h5;
  localparam logic [3:0] OFF_ADDR2 = 4'h6;
  localparam logic [3:0] OFF_ADDR3 = 4'h7;
  localparam logic [3:0] OFF_RES   = 4'h8;
  localparam logic [3:0] OFF_ERR0  = 4'h9;
  localparam logic [3:0] OFF_ERR1  = 4'hA;
  localparam logic [3:0] OFF_ERR2  = 4'hB;
  localparam logic [3:0] OFF_ERR3  = 4'hC;
  localparam logic [3:0] OFF_PEND  = 4'hD;

endpackage

// File: rtl/mb_payload_ram.sv
module mb_payload_ram #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/mb_ctrl.sv
module mb_ctrl
  import mb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostEn,
  input  logic       hostWe,
  input  logic       hostPay,
  input  logic [3:0] hostOff,
  input  logic [7:0] hostWdata,
  input  logic       exDone,
  input  logic       exBufEn,
  output mbStrobe_t  strb,
  output logic       pending,
  output logic       cmdValid
);
  mbState_t state, stateNxt;
  logic idle, hostWrReg;

  always_comb begin
    idle      = (state == ST_IDLE);
    hostWrReg = hostEn & hostWe & ~hostPay;

    strb.opLoad  = idle & hostWrReg & (hostOff == OFF_OPC) & (|hostWdata);
    strb.fieldWr = idle & hostWrReg & (hostOff != OFF_OPC);
    strb.resLoad = (state == ST_BUSY) & exDone;
    strb.opClear = (state == ST_CLOSE);
    strb.bufEx   = ~idle & exBufEn;
    strb.bufHost = ~strb.bufEx & hostEn & hostPay & (~hostWe | idle);

    stateNxt = state;
    unique case (state)
      ST_IDLE:  if (strb.opLoad)  stateNxt = ST_BUSY;
      ST_BUSY:  if (strb.resLoad) stateNxt = ST_CLOSE;
      ST_CLOSE: stateNxt = ST_IDLE;
      default:  stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign pending  = ~idle;
  assign cmdValid = (state == ST_BUSY);
endmodule

// File: rtl/mb_datapath.sv
module mb_datapath
  import mb_pkg::*;
#(
  parameter int         PAY_AW     = 8,
  parameter logic [7:0] READY_CODE = 8'h5A,
  parameter logic [7:0] ERR_CODE   = 8'h84
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbStrobe_t         strb,
  input  logic              pending,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic              hostPay,
  input  logic [3:0]        hostOff,
  input  logic [PAY_AW-1:0] hostBufAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  input  logic [7:0]        exResult,
  input  logic [31:0]       exError,
  input  logic              exBufWe,
  input  logic [PAY_AW-1:0] exBufAddr,
  input  logic [7:0]        exBufWdata,
  output logic [7:0]        exBufRdata,
  output logic [7:0]        opcodeQ,
  output logic [15:0]       sizeQ,
  output logic [31:0]       addrQ,
  output logic [7:0]        resultQ,
  output logic [31:0]       errorQ
);
  logic [7:0]        regByte, rdReg, ramQ, ramWdata;
  logic              rdIsPay, rdGrant, ramEn, ramWe;
  logic [PAY_AW-1:0] ramAddr;

  // staging fields, opcode, completion fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeQ <= '0;
      sizeQ   <= '0;
      addrQ   <= '0;
      resultQ <= READY_CODE;
      errorQ  <= '0;
    end else begin
      if (strb.opLoad)       opcodeQ <= hostWdata;
      else if (strb.opClear) opcodeQ <= '0;
      if (strb.fieldWr) begin
        case (hostOff)
          OFF_SIZE0: sizeQ[7:0]   <= hostWdata;
          OFF_SIZE1: sizeQ[15:8]  <= hostWdata;
          OFF_ADDR0: addrQ[7:0]   <= hostWdata;
          OFF_ADDR1: addrQ[15:8]  <= hostWdata;
          OFF_ADDR2: addrQ[23:16] <= hostWdata;
          OFF_ADDR3: addrQ[31:24] <= hostWdata;
          default: ;
        endcase
      end
      if (strb.resLoad) begin
        resultQ <= exResult;
        errorQ  <= (exResult == ERR_CODE) ? exError : '0;
      end
    end
  end

  always_comb begin
    case (hostOff)
      OFF_OPC:   regByte = opcodeQ;
      OFF_SIZE0: regByte = sizeQ[7:0];
      OFF_SIZE1: regByte = sizeQ[15:8];
      OFF_ADDR0: regByte = addrQ[7:0];
      OFF_ADDR1: regByte = addrQ[15:8];
      OFF_ADDR2: regByte = addrQ[23:16];
      OFF_ADDR3: regByte = addrQ[31:24];
      OFF_RES:   regByte = resultQ;
      OFF_ERR0:  regByte = errorQ[7:0];
      OFF_ERR1:  regByte = errorQ[15:8];
      OFF_ERR2:  regByte = errorQ[23:16];
      OFF_ERR3:  regByte = errorQ[31:24];
      OFF_PEND:  regByte = {7'd0, pending};
      default:   regByte = 8'h00;
    endcase
  end

  // buffer port arbitration
  always_comb begin
    ramEn    = strb.bufEx | strb.bufHost;
    ramWe    = strb.bufEx ? exBufWe    : hostWe;
    ramAddr  = strb.bufEx ? exBufAddr  : hostBufAddr;
    ramWdata = strb.bufEx ? exBufWdata : hostWdata;
  end

  mb_payload_ram #(.AW(PAY_AW)) u_ram (
    .clk   (clk),
    .en    (ramEn),
    .we    (ramWe),
    .addr  (ramAddr),
    .wdata (ramWdata),
    .rdata (ramQ)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdIsPay <= 1'b0;
      rdGrant <= 1'b0;
      rdReg   <= '0;
    end else if (hostEn && !hostWe) begin
      rdIsPay <= hostPay;
      rdGrant <= strb.bufHost;
      if (!hostPay) rdReg <= regByte;
    end
  end

  assign hostRdata  = rdIsPay ? (rdGrant ? ramQ : 8'h00) : rdReg;
  assign exBufRdata = ramQ;
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mb_pkg::*;
#(
  parameter int         PAY_AW     = 8,
  parameter logic [7:0] READY_CODE = 8'h5A,
  parameter logic [7:0] ERR_CODE   = 8'h84
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostEn,
  input  logic              hostWe,
  input  logic [PAY_AW:0]   hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic              cmdValid,
  output logic [7:0]        cmdOpcode,
  output logic [15:0]       cmdSize,
  output logic [31:0]       cmdAddr,
  input  logic              exDone,
  input  logic [7:0]        exResult,
  input  logic [31:0]       exError,
  input  logic              exBufEn,
  input  logic              exBufWe,
  input  logic [PAY_AW-1:0] exBufAddr,
  input  logic [7:0]        exBufWdata,
  output logic [7:0]        exBufRdata
);
  mbStrobe_t   strb;
  logic        pending, hostPay;
  logic [3:0]  hostOff;
  logic [7:0]  resultQ;
  logic [31:0] errorQ;

  assign hostPay = hostAddr[PAY_AW];
  assign hostOff = hostAddr[3:0];

  mb_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostEn    (hostEn),
    .hostWe    (hostWe),
    .hostPay   (hostPay),
    .hostOff   (hostOff),
    .hostWdata (hostWdata),
    .exDone    (exDone),
    .exBufEn   (exBufEn),
    .strb      (strb),
    .pending   (pending),
    .cmdValid  (cmdValid)
  );

  mb_datapath #(
    .PAY_AW     (PAY_AW),
    .READY_CODE (READY_CODE),
    .ERR_CODE   (ERR_CODE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .pending     (pending),
    .hostEn      (hostEn),
    .hostWe      (hostWe),
    .hostPay     (hostPay),
    .hostOff     (hostOff),
    .hostBufAddr (hostAddr[PAY_AW-1:0]),
    .hostWdata   (hostWdata),
    .hostRdata   (hostRdata),
    .exResult    (exResult),
    .exError     (exError),
    .exBufWe     (exBufWe),
    .exBufAddr   (exBufAddr),
    .exBufWdata  (exBufWdata),
    .exBufRdata  (exBufRdata),
    .opcodeQ     (cmdOpcode),
    .sizeQ       (cmdSize),
    .addrQ       (cmdAddr),
    .resultQ     (resultQ),
    .errorQ      (errorQ)
  );
endmodule

// File: rtl/mb_checker.sv
module mb_checker #(
  parameter logic [7:0] ERR_CODE = 8'h84
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostEn,
  input logic        hostWe,
  input logic        hostPay,
  input logic [3:0]  hostOff,
  input logic [7:0]  hostWdata,
  input logic        cmdValid,
  input logic [7:0]  cmdOpcode,
  input logic [15:0] cmdSize,
  input logic [31:0] cmdAddr,
  input logic        exDone,
  input logic [7:0]  exResult,
  input logic        pending,
  input logic [7:0]  resultQ,
  input logic [31:0] errorQ
);
  logic opWr;
  assign opWr = hostEn && hostWe && !hostPay && (hostOff == 4'h0);

  a_r3_opcode_starts: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && opWr && hostWdata != 8'h00) |=> (cmdValid && cmdOpcode == $past(hostWdata)));

  a_r4_zero_opcode_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!pending && opWr && hostWdata == 8'h00) |=> !pending);

  a_r5_result_before_clear: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && exDone) |=> (!cmdValid && pending && cmdOpcode != 8'h00 && resultQ == $past(exResult)));

  a_r5_opcode_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && exDone) |=> ##1 (!pending && cmdOpcode == 8'h00));

  a_r6_error_only_on_err: assert property (@(posedge clk) disable iff (!rstN)
    (resultQ != ERR_CODE) |-> (errorQ == 32'd0));

  a_r7_fields_frozen: assert property (@(posedge clk) disable iff (!rstN)
    pending |=> ($stable(cmdSize) && $stable(cmdAddr)));

  a_r11_stray_done: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |=> ($stable(resultQ) && $stable(errorQ)));
endmodule

bind cmd_mailbox mb_checker #(.ERR_CODE(ERR_CODE)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostEn    (hostEn),
  .hostWe    (hostWe),
  .hostPay   (hostPay),
  .hostOff   (hostOff),
  .hostWdata (hostWdata),
  .cmdValid  (cmdValid),
  .cmdOpcode (cmdOpcode),
  .cmdSize   (cmdSize),
  .cmdAddr   (cmdAddr),
  .exDone    (exDone),
  .exResult  (exResult),
  .pending   (pending),
  .resultQ   (resultQ),
  .errorQ    (errorQ)
);

// File: tb/tb_cmd_mailbox.sv
`timescale 1ns/1ps
module tb_cmd_mailbox;
  localparam int PAY_AW = 6;

  logic              clk = 1'b0;
  logic              rstN;
  logic              hostEn, hostWe;
  logic [PAY_AW:0]   hostAddr;
  logic [7:0]        hostWdata, hostRdata;
  logic              cmdValid;
  logic [7:0]        cmdOpcode;
  logic [15:0]       cmdSize;
  logic [31:0]       cmdAddr;
  logic              exDone;
  logic [7:0]        exResult;
  logic [31:0]       exError;
  logic              exBufEn, exBufWe;
  logic [PAY_AW-1:0] exBufAddr;
  logic [7:0]        exBufWdata, exBufRdata;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  cmd_mailbox #(.PAY_AW(PAY_AW)) dut (.*);

  typedef struct packed {
    logic       wr;
    logic [6:0] a;
    logic [7:0] d;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VT [NV] = '{
    '{1'b0, 7'h08, 8'h00, 8'h5A},  // R1 ready code
    '{1'b0, 7'h00, 8'h00, 8'h00},  // R1 opcode zero
    '{1'b0, 7'h0D, 8'h00, 8'h00},  // R1 not pending
    '{1'b1, 7'h02, 8'h34, 8'h00},
    '{1'b1, 7'h03, 8'h12, 8'h00},
    '{1'b1, 7'h04, 8'hEF, 8'h00},
    '{1'b1, 7'h05, 8'hBE, 8'h00},
    '{1'b1, 7'h06, 8'hAD, 8'h00},
    '{1'b1, 7'h07, 8'hDE, 8'h00},
    '{1'b0, 7'h02, 8'h00, 8'h34},  // R2 size low byte
    '{1'b0, 7'h07, 8'h00, 8'hDE},  // R2 address high byte
    '{1'b1, 7'h08, 8'h77, 8'h00},
    '{1'b0, 7'h08, 8'h00, 8'h5A},  // R8 result read-only
    '{1'b1, 7'h0A, 8'h55, 8'h00},
    '{1'b0, 7'h0A, 8'h00, 8'h00},  // R8 error read-only
    '{1'b0, 7'h0E, 8'h00, 8'h00},  // R2 unused offset
    '{1'b1, 7'h40, 8'hA1, 8'h00},
    '{1'b1, 7'h7F, 8'hC3, 8'h00},
    '{1'b0, 7'h40, 8'h00, 8'hA1},  // R9 first payload byte
    '{1'b0, 7'h7F, 8'h00, 8'hC3},  // R9 last payload byte
    '{1'b1, 7'h00, 8'h00, 8'h00},
    '{1'b0, 7'h0D, 8'h00, 8'h00}   // R4 zero opcode left idle
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = a;
    @(negedge clk);
    d = hostRdata;
    hostEn = 1'b0;
  endtask

  task automatic exAcc(input logic we, input logic [PAY_AW-1:0] a, input logic [7:0] d,
                       output logic [7:0] q);
    @(negedge clk);
    exBufEn = 1'b1; exBufWe = we; exBufAddr = a; exBufWdata = d;
    @(negedge clk);
    q = exBufRdata;
    exBufEn = 1'b0; exBufWe = 1'b0;
  endtask

  task automatic finishCmd(input logic [7:0] res, input logic [31:0] err);
    @(negedge clk);
    exDone = 1'b1; exResult = res; exError = err;
    @(negedge clk);
    exDone = 1'b0;
  endtask

  initial begin
    logic [7:0] rd, q;
    rstN = 1'b0; hostEn = 1'b0; hostWe = 1'b0; hostAddr = '0; hostWdata = '0;
    exDone = 1'b0; exResult = '0; exError = '0;
    exBufEn = 1'b0; exBufWe = 1'b0; exBufAddr = '0; exBufWdata = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 cmdValid", {31'd0, cmdValid}, 32'd0);
    chk("R1 cmdOpcode", {24'd0, cmdOpcode}, 32'd0);
    chk("R1 cmdSize", {16'd0, cmdSize}, 32'd0);
    chk("R1 cmdAddr", cmdAddr, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VT[i].wr) hostWr(VT[i].a, VT[i].d);
      else begin
        hostRd(VT[i].a, rd);
        chk($sformatf("R2/R9 vector %0d", i), {24'd0, rd}, {24'd0, VT[i].exp});
      end
    end
    chk("R2 size little-endian", {16'd0, cmdSize}, 32'h0000_1234);
    chk("R2 address little-endian", cmdAddr, 32'hDEAD_BEEF);
    chk("R4 no command", {31'd0, cmdValid}, 32'd0);

    // start a command
    hostWr(7'h00, 8'h91);
    chk("R3 cmdValid", {31'd0, cmdValid}, 32'd1);
    chk("R3 cmdOpcode", {24'd0, cmdOpcode}, 32'h91);
    hostRd(7'h0D, rd);
    chk("R2 pending flag", {24'd0, rd}, 32'd1);

    // writes while pending are dropped
    hostWr(7'h02, 8'hFF);
    hostWr(7'h40, 8'h00);
    hostWr(7'h00, 8'h22);
    chk("R7 size frozen", {16'd0, cmdSize}, 32'h1234);
    chk("R7 opcode frozen", {24'd0, cmdOpcode}, 32'h91);

    exAcc(1'b1, 6'h05, 8'h66, q);
    exAcc(1'b0, 6'h00, 8'h00, q);
    chk("R7 payload write dropped", {24'd0, q}, 32'hA1);

    // executor wins the port
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = 7'h45;
    exBufEn = 1'b1; exBufWe = 1'b0; exBufAddr = 6'h05;
    @(negedge clk);
    chk("R9 executor read", {24'd0, exBufRdata}, 32'h66);
    chk("R9 host denied", {24'd0, hostRdata}, 32'h00);
    hostEn = 1'b0; exBufEn = 1'b0;

    // completion with error
    @(negedge clk);
    exDone = 1'b1; exResult = 8'h84; exError = 32'hCAFE_F00D;
    @(negedge clk);
    exDone = 1'b0;
    chk("R5 cmdValid dropped", {31'd0, cmdValid}, 32'd0);
    chk("R5 opcode held one cycle", {24'd0, cmdOpcode}, 32'h91);
    @(negedge clk);
    chk("R5 opcode cleared", {24'd0, cmdOpcode}, 32'h00);
    hostRd(7'h08, rd); chk("R5 result", {24'd0, rd}, 32'h84);
    hostRd(7'h09, rd); chk("R6 error byte0", {24'd0, rd}, 32'h0D);
    hostRd(7'h0A, rd); chk("R6 error byte1", {24'd0, rd}, 32'hF0);
    hostRd(7'h0B, rd); chk("R6 error byte2", {24'd0, rd}, 32'hFE);
    hostRd(7'h0C, rd); chk("R6 error byte3", {24'd0, rd}, 32'hCA);
    hostRd(7'h0D, rd); chk("R5 pending low", {24'd0, rd}, 32'd0);
    hostRd(7'h45, rd); chk("R9 executor write landed", {24'd0, rd}, 32'h66);

    // stray completion and stray executor access while idle
    finishCmd(8'h83, 32'h1111_2222);
    hostRd(7'h08, rd); chk("R11 result unchanged", {24'd0, rd}, 32'h84);
    hostRd(7'h09, rd); chk("R11 error unchanged", {24'd0, rd}, 32'h0D);
    exAcc(1'b1, 6'h05, 8'h11, q);
    hostRd(7'h45, rd); chk("R10 idle executor write dropped", {24'd0, rd}, 32'h66);

    // second command, success result clears error word
    hostWr(7'h00, 8'h80);
    chk("R3 second start", {31'd0, cmdValid}, 32'd1);
    finishCmd(8'h83, 32'h1234_5678);
    @(negedge clk);
    hostRd(7'h08, rd); chk("R5 success result", {24'd0, rd}, 32'h83);
    hostRd(7'h0C, rd); chk("R6 error cleared", {24'd0, rd}, 32'h00);
    hostRd(7'h09, rd); chk("R6 error low cleared", {24'd0, rd}, 32'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule